// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block holds the programming word of an integer-N frequency synthesizer. A 20-bit primary word carries the main divider (9 bits), the reference divider (6 bits), the swallow counter (4 bits) and a prescaler enable. An 8-bit enhancement word carries output and power controls. Three load paths fill these registers, and two mode pins choose between them. The first path takes byte-wide writes from a data bus under separate strobes. The second shifts in serial frames with a serial clock, and the level of the enhancement strobe decides whether a frame is a primary frame or an enhancement frame. The third copies the counter fields straight from a 16-bit pin bus.

Every strobe, the serial clock and the serial data pass through a two-flop synchronizer and an edge detector in the single system clock domain. The system clock must therefore run at least four times faster than the serial clock. A serial frame that ends with the wrong number of shifted bits is thrown away, and an error flag pulses for one cycle. The decoded divider values hold their value between load events.

Top module: `synth_prog_if`

## Requirements
- R1: While rst_n is low, and after it is released with no load event, every output is 0.
- R2: mode_direct high selects direct loading, whatever the level of mode_serial. With mode_direct low, mode_serial high selects serial loading and mode_serial low selects byte loading.
- R3: The primary word, from bit 19 down to bit 0, is {r[5:4], m[8:7], pre_en, m[6:0], r[3:0], a[3:0]}. In byte mode a rising wr_hi loads data_in[3:0] into bits 19..16, a rising wr_mid loads data_in[7:0] into bits 15..8, and a rising wr_lo loads data_in[7:0] into bits 7..0.
- R4: In byte mode a rising wr_enh loads data_in[7:0] into the enhancement word.
- R5: In serial mode each rising sclk shifts sdata in, most significant bit first. A rising wr_sec copies the last 20 bits into the primary word when exactly 20 bits have been shifted since the last frame boundary.
- R6: In serial mode a rising wr_enh starts an enhancement frame. A falling wr_enh copies the last 8 shifted bits into the enhancement word when exactly 8 bits were shifted.
- R7: A serial frame ending with any other bit count leaves both words unchanged, and frame_err is high for exactly one cycle.
- R8: In direct mode the primary word follows {4'b0000, pin_word}, so m[8:7] and r[5:4] read 0.
- R9: The enhancement word maps bit 4 to pwr_down, bit 3 to cnt_load, bit 2 to msel_out, bit 1 to pre_out and bit 0 to fcfp_oe. Bits 7..5 are reserved. These outputs follow the word only while enh_n is low, and read 0 while it is high.
- R10: Outside a load event the decoded outputs stay stable. Strobes and shifts that belong to another load mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | Selects direct pin loading |
| mode_serial | input | 1 | Selects serial loading when not in direct mode |
| enh_n | input | 1 | Active-low enable of the enhancement outputs |
| data_in | input | 8 | Byte bus for byte mode |
| pin_word | input | 16 | Counter fields for direct mode: pre_en, m[6:0], r[3:0], a[3:0] |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, most significant bit first |
| wr_hi | input | 1 | Byte strobe for the top nibble of the primary word |
| wr_mid | input | 1 | Byte strobe for the prescaler enable and m[6:0] |
| wr_lo | input | 1 | Byte strobe for r[3:0] and a[3:0] |
| wr_enh | input | 1 | Enhancement strobe; in serial mode it also marks the frame type |
| wr_sec | input | 1 | Serial primary frame capture strobe |
| m_count | output | 9 | Main divider value |
| r_count | output | 6 | Reference divider value |
| a_count | output | 4 | Swallow counter value |
| pre_en | output | 1 | Prescaler enable |
| pwr_down | output | 1 | Gated power-down control |
| cnt_load | output | 1 | Gated counter-load control |
| msel_out | output | 1 | Gated main-select output enable |
| pre_out | output | 1 | Gated prescaler output enable |
| fcfp_oe | output | 1 | Gated reference/comparison frequency output enable |
| frame_err | output | 1 | One-cycle pulse on a discarded serial frame |

## Verification
The bench sends serial frames one bit short of a primary frame and one bit long for an enhancement frame. A design that counts loosely would take a shifted word, and a design that checks the count would still miss the error pulse. It pulses the byte strobes during serial mode, and pulses sclk and wr_sec during byte mode. A design that decodes the modes wrongly would alter the word on these stray strobes. Direct mode is driven with all pins high, which exposes any leak into the forced-zero high divider bits. The bench then leaves direct mode, and a design that kept tracking the pins would change the outputs. Toggling enh_n around a loaded enhancement word catches outputs that are not gated.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int PRIM_W = 20;
  localparam int ENH_W  = 8;
  localparam int PIN_W  = 16;
  localparam int CNT_W  = $clog2(PRIM_W + 1);
  localparam int HI_LSB = 16;
  localparam int MID_LSB = 8;
  localparam int CTL_W  = 5;

  typedef enum logic [1:0] {LD_BYTE, LD_SERIAL, LD_DIRECT} load_mode_e;

  function automatic load_mode_e pick_mode(input logic direct, input logic serial);
    if (direct) return LD_DIRECT;
    if (serial) return LD_SERIAL;
    return LD_BYTE;
  endfunction

  function automatic logic [8:0] main_of(input logic [PRIM_W-1:0] w);
    return {w[17:16], w[14:8]};
  endfunction

  function automatic logic [5:0] ref_of(input logic [PRIM_W-1:0] w);
    return {w[19:18], w[7:4]};
  endfunction

  function automatic logic [3:0] swallow_of(input logic [PRIM_W-1:0] w);
    return w[3:0];
  endfunction

  function automatic logic [CTL_W-1:0] ctl_of(input logic [ENH_W-1:0] e, input logic gate_n);
    return gate_n ? '0 : e[CTL_W-1:0];
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= din;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/serial_frame.sv
module serial_frame
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              shift_evt,
  input  logic              bit_in,
  input  logic              clear,
  output logic [PRIM_W-1:0] shreg,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (enable && shift_evt) begin
      shreg <= {shreg[PRIM_W-2:0], bit_in};
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/word_store.sv
module word_store
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  load_mode_e        mode,
  input  logic [7:0]        data_in,
  input  logic [PIN_W-1:0]  pin_word,
  input  logic              hi_rise,
  input  logic              mid_rise,
  input  logic              lo_rise,
  input  logic              enh_rise,
  input  logic              enh_fall,
  input  logic              sec_rise,
  input  logic [PRIM_W-1:0] shreg,
  input  logic [CNT_W-1:0]  count,
  output logic [PRIM_W-1:0] prim_word,
  output logic [ENH_W-1:0]  enh_word,
  output logic              frame_err,
  output logic              prim_load,
  output logic              clear_cnt
);
  logic is_byte, is_ser, is_dir;
  logic ser_prim_end, ser_enh_end, prim_ok, enh_ok, bad_frame, enh_load;

  assign is_byte = (mode == LD_BYTE);
  assign is_ser  = (mode == LD_SERIAL);
  assign is_dir  = (mode == LD_DIRECT);

  assign ser_prim_end = is_ser && sec_rise;
  assign ser_enh_end  = is_ser && enh_fall;
  assign prim_ok      = ser_prim_end && (count == CNT_W'(PRIM_W));
  assign enh_ok       = ser_enh_end && (count == CNT_W'(ENH_W));
  assign bad_frame    = (ser_prim_end && !prim_ok) || (ser_enh_end && !enh_ok);
  assign clear_cnt    = ser_prim_end || ser_enh_end || (is_ser && enh_rise);
  assign prim_load    = is_dir || prim_ok || (is_byte && (hi_rise || mid_rise || lo_rise));
  assign enh_load     = enh_ok || (is_byte && enh_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_word <= '0;
    end else if (is_dir) begin
      prim_word <= {{(PRIM_W-PIN_W){1'b0}}, pin_word};
    end else if (prim_ok) begin
      prim_word <= shreg;
    end else if (is_byte) begin
      if (hi_rise)  prim_word[PRIM_W-1:HI_LSB]  <= data_in[PRIM_W-HI_LSB-1:0];
      if (mid_rise) prim_word[HI_LSB-1:MID_LSB] <= data_in;
      if (lo_rise)  prim_word[MID_LSB-1:0]      <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enh_word  <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= bad_frame;
      if (enh_load) enh_word <= enh_ok ? shreg[ENH_W-1:0] : data_in;
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_direct,
  input  logic        mode_serial,
  input  logic        enh_n,
  input  logic [7:0]  data_in,
  input  logic [15:0] pin_word,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        wr_hi,
  input  logic        wr_mid,
  input  logic        wr_lo,
  input  logic        wr_enh,
  input  logic        wr_sec,
  output logic [8:0]  m_count,
  output logic [5:0]  r_count,
  output logic [3:0]  a_count,
  output logic        pre_en,
  output logic        pwr_down,
  output logic        cnt_load,
  output logic        msel_out,
  output logic        pre_out,
  output logic        fcfp_oe,
  output logic        frame_err
);
  localparam int NSYNC = 7;
  localparam int I_HI = 0, I_MID = 1, I_LO = 2, I_ENH = 3, I_SEC = 4, I_SCK = 5, I_SDA = 6;

  load_mode_e        mode;
  logic [NSYNC-1:0]  raw, lvl, rise, fall;
  logic [PRIM_W-1:0] shreg, prim_word;
  logic [CNT_W-1:0]  count;
  logic [ENH_W-1:0]  enh_word;
  logic              prim_load, clear_cnt;
  logic [CTL_W-1:0]  ctl;
  logic              sig_unused;

  assign mode = pick_mode(mode_direct, mode_serial);
  assign raw  = {sdata, sclk, wr_sec, wr_enh, wr_lo, wr_mid, wr_hi};

  sync_edge #(.WIDTH(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .level(lvl), .rise(rise), .fall(fall)
  );

  serial_frame u_shift (
    .clk(clk), .rst_n(rst_n), .enable(mode == LD_SERIAL), .shift_evt(rise[I_SCK]),
    .bit_in(lvl[I_SDA]), .clear(clear_cnt), .shreg(shreg), .count(count)
  );

  word_store u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .data_in(data_in), .pin_word(pin_word),
    .hi_rise(rise[I_HI]), .mid_rise(rise[I_MID]), .lo_rise(rise[I_LO]),
    .enh_rise(rise[I_ENH]), .enh_fall(fall[I_ENH]), .sec_rise(rise[I_SEC]),
    .shreg(shreg), .count(count), .prim_word(prim_word), .enh_word(enh_word),
    .frame_err(frame_err), .prim_load(prim_load), .clear_cnt(clear_cnt)
  );

  assign sig_unused = ^{lvl[I_SCK:I_HI], rise[I_SDA], fall[I_SDA:I_SEC], fall[I_LO:I_HI]};

  assign m_count = main_of(prim_word);
  assign r_count = ref_of(prim_word);
  assign a_count = swallow_of(prim_word);
  assign pre_en  = prim_word[15];
  assign ctl     = ctl_of(enh_word, enh_n);
  assign {pwr_down, cnt_load, msel_out, pre_out, fcfp_oe} = ctl;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_direct,
  input logic       enh_n,
  input logic [8:0] m_count,
  input logic [5:0] r_count,
  input logic [3:0] a_count,
  input logic       pre_en,
  input logic [4:0] ctl,
  input logic       frame_err,
  input logic       prim_load,
  input logic [7:0] enh_word
);
  AST_DIRECT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_direct && $past(mode_direct)) |-> (m_count[8:7] == 2'b00 && r_count[5:4] == 2'b00)); // R8

  AST_ENH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n |-> (ctl == 5'b0)); // R9

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R7

  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($stable({m_count, r_count, a_count, pre_en}) && $stable(enh_word))); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_load |=> $stable({m_count, r_count, a_count, pre_en})); // R10
endmodule

bind synth_prog_if synth_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .enh_n(enh_n),
  .m_count(m_count), .r_count(r_count), .a_count(a_count), .pre_en(pre_en),
  .ctl(ctl), .frame_err(frame_err), .prim_load(prim_load), .enh_word(enh_word)
);

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_direct = 1'b0, mode_serial = 1'b0, enh_n = 1'b0;
  logic [7:0] data_in = '0;
  logic [15:0] pin_word = '0;
  logic sclk = 1'b0, sdata = 1'b0;
  logic [4:0] strb = '0; // 0 hi, 1 mid, 2 lo, 3 enh, 4 sec
  logic [8:0] m_count; logic [5:0] r_count; logic [3:0] a_count;
  logic pre_en, pwr_down, cnt_load, msel_out, pre_out, fcfp_oe, frame_err;

  synth_prog_if uut (
    .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .mode_serial(mode_serial),
    .enh_n(enh_n), .data_in(data_in), .pin_word(pin_word), .sclk(sclk), .sdata(sdata),
    .wr_hi(strb[0]), .wr_mid(strb[1]), .wr_lo(strb[2]), .wr_enh(strb[3]), .wr_sec(strb[4]),
    .m_count(m_count), .r_count(r_count), .a_count(a_count), .pre_en(pre_en),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .msel_out(msel_out), .pre_out(pre_out),
    .fcfp_oe(fcfp_oe), .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  typedef struct { string req; logic [19:0] w; logic [4:0] ctl; int errs; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, err_seen = 0;
  logic [19:0] ew = '0;
  logic [7:0]  ee = '0;
  int eerrs = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n && frame_err) err_seen++;

  // monitor: pops expected items and compares with the ports
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t it;
      logic [19:0] obs;
      logic [4:0] octl;
      it = q.pop_front();
      obs = {r_count[5:4], m_count[8:7], pre_en, m_count[6:0], r_count[3:0], a_count};
      octl = {pwr_down, cnt_load, msel_out, pre_out, fcfp_oe};
      checks++;
      if (obs !== it.w || octl !== it.ctl || err_seen != it.errs) begin
        fails++;
        $display("FAIL %s: word=%h ctl=%b errs=%0d expected word=%h ctl=%b errs=%0d",
                 it.req, obs, octl, err_seen, it.w, it.ctl, it.errs);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string req);
    wait_cyc(2);
    q.push_back('{req, ew, (enh_n ? 5'b0 : ee[4:0]), eerrs});
    wait_cyc(2);
  endtask

  task automatic strobe(input int idx);
    strb[idx] = 1'b1; wait_cyc(6);
    strb[idx] = 1'b0; wait_cyc(6);
  endtask

  task automatic ser_bit(input logic b);
    sdata = b; wait_cyc(4);
    sclk = 1'b1; wait_cyc(4);
    sclk = 1'b0; wait_cyc(4);
  endtask

  task automatic ser_bits(input logic [19:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R1..all): run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    expect_now("R1 outputs during reset");
    rst_n = 1'b1;
    wait_cyc(4);
    expect_now("R1 outputs after reset release");

    // byte mode, R2 R3
    data_in = 8'hA5; strobe(0); ew[19:16] = 4'h5;
    expect_now("R3 wr_hi nibble");
    data_in = 8'hC3; strobe(1); ew[15:8] = 8'hC3;
    data_in = 8'h5A; strobe(2); ew[7:0] = 8'h5A;
    expect_now("R3 wr_mid and wr_lo bytes");

    // R4 and R9
    data_in = 8'hF6; strobe(3); ee = 8'hF6;
    expect_now("R4 byte enhancement load, R9 mapping");
    enh_n = 1'b1;
    expect_now("R9 enh_n high gates controls");
    enh_n = 1'b0;
    expect_now("R9 enh_n low restores controls");

    // R10 serial shifts and wr_sec ignored in byte mode
    ser_bits(20'hFFFFF, 20); strobe(4);
    expect_now("R10 serial strobes ignored in byte mode");

    // serial mode, R2 R5
    mode_serial = 1'b1; wait_cyc(2);
    ser_bits(20'hABCDE, 20); strobe(4); ew = 20'hABCDE;
    expect_now("R5 serial primary frame");

    // R6 enhancement frame
    strb[3] = 1'b1; wait_cyc(6);
    ser_bits(20'h00095, 8);
    strb[3] = 1'b0; wait_cyc(6); ee = 8'h95;
    expect_now("R6 serial enhancement frame");

    // R7 short primary
    ser_bits(20'h12345, 19); strobe(4); eerrs++;
    expect_now("R7 19-bit primary frame discarded");

    // R7 long enhancement
    strb[3] = 1'b1; wait_cyc(6);
    ser_bits(20'h001AA, 9);
    strb[3] = 1'b0; wait_cyc(6); eerrs++;
    expect_now("R7 9-bit enhancement frame discarded");

    // R10 byte strobes ignored in serial mode
    data_in = 8'hFF; strobe(0); strobe(1); strobe(2);
    expect_now("R10 byte strobes ignored in serial mode");

    // direct mode, R2 R8 (mode_serial still high)
    pin_word = 16'hFFFF; mode_direct = 1'b1; wait_cyc(3); ew = 20'h0FFFF;
    expect_now("R8 direct all ones, high bits forced zero");
    pin_word = 16'h1234; wait_cyc(3); ew = 20'h01234;
    expect_now("R8 direct follows pins");

    // leave direct: R10 hold
    mode_direct = 1'b0; mode_serial = 1'b0; wait_cyc(3);
    pin_word = 16'hBEEF; wait_cyc(3);
    expect_now("R10 word held after leaving direct mode");

    wait_cyc(4);
    while (q.size() > 0) wait_cyc(1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule